// File: doc/BRIEF.md
# Raster Timing Controller

This block drives the sweep of a raster display. Software programs the line period, frame period, sync widths, the wait counts (sync plus back porch) and the active area through a small write port. Once started, the block walks a pixel counter and a line counter, and from them it generates horizontal and vertical sync with a polarity chosen for each axis. It also produces a data-enable strobe and the coordinates of the pixel being shown.

During active pixels the block raises a request toward an external fetch unit. That unit answers in the same cycle with a valid bit and a pixel index. A missing answer is an underflow. In recover mode the rest of that line is shown as index 0 and the raster keeps running. Without recover mode the raster halts.

The block keeps a current and a next frame-buffer base address, and copies next into current when each frame ends. Four event flags (frame done, vsync edge, underflow, overflow) are cleared by writing ones to them, and each has an enable bit that gates it onto a single interrupt line.

Top module: `raster_timing_ctrl`

## Requirements
- R1: Register 1 holds the line period in clocks in bits [15:0] and the hsync width in bits [31:16]. While running, every line lasts exactly the line period, and hsync is active during the first hsync-width clocks of each line.
- R2: Register 2 holds the frame length in lines in bits [15:0] and the vsync width in lines in bits [31:16]. Every frame lasts exactly that many lines, and vsync is active during the first vsync-width lines of each frame.
- R3: Register 3 holds the horizontal wait in bits [15:0] and the vertical wait in bits [31:16]. Register 4 holds the active width in bits [15:0] and the active height in bits [31:16]. de_o and req_valid_o are high only on pixels inside the active window, which starts a wait count after the start of the line and of the frame. There pix_x_o and pix_y_o give the offsets from the window origin; elsewhere they are 0.
- R4: Register 0 bit 1 selects the hsync polarity and bit 2 the vsync polarity (0 is active low, 1 is active high). When the raster is idle, both syncs sit at their inactive level.
- R5: Register 0 bit 0 is the run bit. Setting it while idle starts the raster at line 0, pixel 0 on the next clock. Clearing it lets the current frame finish, after which the block is idle.
- R6: Register 5 holds the next base address. At the last clock of each frame it is copied into cur_base_o.
- R7: flags_o bit 0 is frame done, set at the end of each frame. Bit 1 is vsync edge, set at each frame start. Bit 2 is underflow and bit 3 is overflow. Writing ones to register 6 clears the matching flags; a new event in the same clock wins.
- R8: Register 7 holds the enables in the same bit order as the flags. irq_o is high when any flag is set together with its enable.
- R9: With register 0 bit 3 (recover) set, a request that is not answered sets the underflow flag. pix_o is 0 from that pixel to the end of its line, and the sync timing is unchanged.
- R10: With recover clear, an unanswered request sets the underflow flag, returns the raster to idle on the next clock and clears the run bit, so the raster stays idle until run is written again.
- R11: A response valid while no request is pending sets the overflow flag and leaves pix_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| req_valid_o | output | 1 | Pixel request to the fetch unit |
| rsp_valid_i | input | 1 | Fetch unit has a pixel this cycle |
| rsp_data_i | input | 8 | Pixel index from the fetch unit |
| hsync_o | output | 1 | Horizontal sync, polarity per register 0 |
| vsync_o | output | 1 | Vertical sync, polarity per register 0 |
| de_o | output | 1 | Active-area strobe |
| pix_x_o | output | 16 | Column inside the active window |
| pix_y_o | output | 16 | Row inside the active window |
| pix_o | output | 8 | Pixel index shown |
| cur_base_o | output | 32 | Current frame-buffer base |
| flags_o | output | 4 | Event flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default 16-bit counters and an 8-bit pixel index. At run time it programs a miniature raster of 12 clocks by 8 lines, with a 5 by 3 active window, 2-clock hsync and 1-line vsync. With a frame only 96 clocks long, every clock of whole frames, the frame-boundary buffer swap, the finish-then-stop behaviour, both polarity settings and both underflow modes can all be compared cycle by cycle against a queue of expected values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int CW     = 16;
    localparam int BUS_W  = 32;
    localparam int HALF   = BUS_W / 2;
    localparam int AW     = 32;
    localparam int DW     = 8;
    localparam int RAW    = 3;
    localparam int NFLAG  = 4;
    localparam int FL_DONE  = 0;
    localparam int FL_VEDGE = 1;
    localparam int FL_UNDER = 2;
    localparam int FL_OVER  = 3;

    typedef enum logic [RAW-1:0] {
        REG_CTRL = 3'd0,
        REG_HTIM = 3'd1,
        REG_VTIM = 3'd2,
        REG_WAIT = 3'd3,
        REG_ACT  = 3'd4,
        REG_NBUF = 3'd5,
        REG_FLAG = 3'd6,
        REG_IEN  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [CW-1:0] period;
        logic [CW-1:0] sync;
        logic [CW-1:0] lead;
        logic [CW-1:0] count;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t h;
        axis_cfg_t v;
        logic      hpol;
        logic      vpol;
        logic      recover;
    } rtc_cfg_t;

    function automatic logic drive_level(input logic act, input logic pol);
        return pol ? act : ~act;
    endfunction
endpackage

// File: rtl/rtc_axis.sv
module rtc_axis
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  axis_cfg_t     cfg,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] pos,
    output logic          wrap,
    output logic          sync_act,
    output logic          in_win
);
    logic        last;
    logic [CW:0] win_end;

    assign last     = (cnt == cfg.period - 1'b1);
    assign wrap     = step && last;
    assign sync_act = (cnt < cfg.sync);
    assign win_end  = {1'b0, cfg.lead} + {1'b0, cfg.count};
    assign in_win   = ({1'b0, cnt} >= {1'b0, cfg.lead}) && ({1'b0, cnt} < win_end);
    assign pos      = cnt - cfg.lead;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // R1 (and R2 for the vertical instance): the period ends after exactly period steps
    p_axis_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (step && last && !clr) |=> (cnt == '0));
    p_axis_step_r1: assert property (@(posedge clk) disable iff (rst)
        (step && !last && !clr) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rtc_scan.sv
module rtc_scan
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  rtc_cfg_t      cfg,
    input  logic          run,
    input  logic          halt,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          line_end,
    output logic          frame_end,
    output logic          vedge_ev
);
    logic          running, start, clr;
    logic [CW-1:0] h_cnt, v_cnt, h_pos, v_pos;
    logic          h_wrap, v_wrap, h_sync, v_sync, h_in, v_in;

    assign start     = !running && run && !halt;
    assign clr       = !running || halt;
    assign frame_end = v_wrap;
    assign line_end  = h_wrap;
    assign vedge_ev  = start || (frame_end && run && !halt);

    rtc_axis u_h (.clk(clk), .rst(rst), .clr(clr), .step(running), .cfg(cfg.h),
                  .cnt(h_cnt), .pos(h_pos), .wrap(h_wrap), .sync_act(h_sync), .in_win(h_in));
    rtc_axis u_v (.clk(clk), .rst(rst), .clr(clr), .step(running && h_wrap), .cfg(cfg.v),
                  .cnt(v_cnt), .pos(v_pos), .wrap(v_wrap), .sync_act(v_sync), .in_win(v_in));

    always_ff @(posedge clk) begin
        if (rst)                     running <= 1'b0;
        else if (halt)               running <= 1'b0;
        else if (start)              running <= 1'b1;
        else if (frame_end && !run)  running <= 1'b0;
    end

    assign de_o    = running && h_in && v_in;
    assign x_o     = de_o ? h_pos : '0;
    assign y_o     = de_o ? v_pos : '0;
    assign hsync_o = drive_level(running && h_sync, cfg.hpol);
    assign vsync_o = drive_level(running && v_sync, cfg.vpol);

    // R4: idle raster holds both syncs inactive
    p_idle_levels_r4: assert property (@(posedge clk) disable iff (rst)
        !running |-> (hsync_o == ~cfg.hpol) && (vsync_o == ~cfg.vpol));
    // R5: a fresh start begins at the origin
    p_origin_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (h_cnt == '0) && (v_cnt == '0));
    // R5: clearing run mid-frame does not cut the frame short
    p_finish_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (running && !frame_end && !halt) |=> running);
    // R3: no data enable before the horizontal wait has elapsed
    p_de_after_wait_r3: assert property (@(posedge clk) disable iff (rst)
        de_o |-> (h_cnt >= cfg.h.lead) && (v_cnt >= cfg.v.lead));
endmodule

// File: rtl/rtc_pixel.sv
module rtc_pixel
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          de,
    input  logic          line_end,
    input  logic          recover,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic [DW-1:0] pix_o,
    output logic          under_ev,
    output logic          over_ev,
    output logic          halt_req
);
    logic blank;

    assign under_ev = de && !rsp_valid;
    assign over_ev  = rsp_valid && !de;
    assign halt_req = under_ev && !recover;
    assign pix_o    = (de && rsp_valid && !blank) ? rsp_data : '0;

    always_ff @(posedge clk) begin
        if (rst || line_end)              blank <= 1'b0;
        else if (under_ev && recover)     blank <= 1'b1;
    end

    // R9: once a line has lost a pixel, the rest of it shows index 0
    p_blank_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (blank && de) |-> (pix_o == '0));
    // R9: the blanking lasts only to the end of the line
    p_blank_clear_r9: assert property (@(posedge clk) disable iff (rst)
        line_end |=> !blank);
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RAW-1:0]   wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             done_ev,
    input  logic             vedge_ev,
    input  logic             under_ev,
    input  logic             over_ev,
    input  logic             halt_req,
    output rtc_cfg_t         cfg,
    output logic             run,
    output logic [AW-1:0]    cur_base,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    reg_sel_e         sel;
    logic [AW-1:0]    next_base;
    logic [NFLAG-1:0] ien, ev, w1c;

    assign sel = reg_sel_e'(wr_addr);
    assign ev  = {over_ev, under_ev, vedge_ev, done_ev};
    assign w1c = (wr_en && sel == REG_FLAG) ? wr_data[NFLAG-1:0] : '0;
    assign irq = |(flags & ien);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            run       <= 1'b0;
            next_base <= '0;
            cur_base  <= '0;
            ien       <= '0;
            flags     <= '0;
        end else begin
            if (wr_en) begin
                case (sel)
                    REG_CTRL: {cfg.recover, cfg.vpol, cfg.hpol, run} <= wr_data[3:0];
                    REG_HTIM: begin cfg.h.period <= wr_data[CW-1:0]; cfg.h.sync  <= wr_data[HALF+:CW]; end
                    REG_VTIM: begin cfg.v.period <= wr_data[CW-1:0]; cfg.v.sync  <= wr_data[HALF+:CW]; end
                    REG_WAIT: begin cfg.h.lead   <= wr_data[CW-1:0]; cfg.v.lead  <= wr_data[HALF+:CW]; end
                    REG_ACT:  begin cfg.h.count  <= wr_data[CW-1:0]; cfg.v.count <= wr_data[HALF+:CW]; end
                    REG_NBUF: next_base <= wr_data[AW-1:0];
                    REG_IEN:  ien <= wr_data[NFLAG-1:0];
                    default:  ;
                endcase
            end
            if (halt_req) run <= 1'b0;
            if (done_ev)  cur_base <= next_base;
            flags <= (flags & ~w1c) | ev;
        end
    end

    // R6: the queued base becomes current at the frame boundary
    p_promote_r6: assert property (@(posedge clk) disable iff (rst)
        done_ev |=> (cur_base == $past(next_base)));
    // R7: an event always leaves its flag set
    p_done_flag_r7: assert property (@(posedge clk) disable iff (rst)
        done_ev |=> flags[FL_DONE]);
    // R7: writing one clears a flag when no new event arrives
    p_w1c_over_r7: assert property (@(posedge clk) disable iff (rst)
        (w1c[FL_OVER] && !over_ev) |=> !flags[FL_OVER]);
    // R10: an unrecovered underflow drops the run bit
    p_halt_run_r10: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> !run);
endmodule

// File: rtl/raster_timing_ctrl.sv
module raster_timing_ctrl
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RAW-1:0]   wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    output logic             req_valid_o,
    input  logic             rsp_valid_i,
    input  logic [DW-1:0]    rsp_data_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [CW-1:0]    pix_x_o,
    output logic [CW-1:0]    pix_y_o,
    output logic [DW-1:0]    pix_o,
    output logic [AW-1:0]    cur_base_o,
    output logic [NFLAG-1:0] flags_o,
    output logic             irq_o
);
    rtc_cfg_t cfg;
    logic     run, halt_req, line_end, frame_end, vedge_ev, under_ev, over_ev;

    rtc_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done_ev(frame_end), .vedge_ev(vedge_ev), .under_ev(under_ev), .over_ev(over_ev),
        .halt_req(halt_req), .cfg(cfg), .run(run), .cur_base(cur_base_o),
        .flags(flags_o), .irq(irq_o)
    );

    rtc_scan u_scan (
        .clk(clk), .rst(rst), .cfg(cfg), .run(run), .halt(halt_req),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .x_o(pix_x_o), .y_o(pix_y_o),
        .line_end(line_end), .frame_end(frame_end), .vedge_ev(vedge_ev)
    );

    rtc_pixel u_pix (
        .clk(clk), .rst(rst), .de(de_o), .line_end(line_end), .recover(cfg.recover),
        .rsp_valid(rsp_valid_i), .rsp_data(rsp_data_i), .pix_o(pix_o),
        .under_ev(under_ev), .over_ev(over_ev), .halt_req(halt_req)
    );

    assign req_valid_o = de_o;

    // R10: a halt takes the raster off the active area on the next clock
    p_halt_stops_r10: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> !de_o && !req_valid_o);
    // R11: a stray response never reaches the pixel output
    p_stray_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_i && !req_valid_o) |-> (pix_o == '0));
endmodule

// File: tb/sim_raster_timing_ctrl.sv
module sim_raster_timing_ctrl;
    import rtc_pkg::*;

    localparam int HP = 12, HSW = 2, HW = 4, WID = 5;
    localparam int VP = 8,  VSW = 1, VW = 3, HGT = 3;
    localparam int FRAME = HP * VP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid, rsp_valid, hsync, vsync, de, irq;
    logic [7:0]  rsp_data, pix;
    logic [15:0] px, py;
    logic [31:0] cur_base;
    logic [3:0]  flags;

    int   kx = -1, ky = -1;
    logic kill_arm = 1'b0;
    logic extra_rsp = 1'b0;
    logic hp = 1'b0, vp = 1'b0;
    int   n_chk = 0, n_fail = 0;

    typedef struct {
        logic        hs, vs, de;
        logic [15:0] x, y;
        logic [7:0]  pix;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    wire kill_hit = kill_arm && de && (int'(px) == kx) && (int'(py) == ky);
    assign rsp_valid = (req_valid && !kill_hit) || extra_rsp;
    assign rsp_data  = {px[3:0], py[3:0]};

    raster_timing_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .req_valid_o(req_valid), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
        .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_x_o(px), .pix_y_o(py),
        .pix_o(pix), .cur_base_o(cur_base), .flags_o(flags), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(input bit run, input bit rec);
        return {28'b0, rec, vp, hp, run};
    endfunction

    // driver: expected outputs for ncyc clocks from the origin
    task automatic push_seq(input int ncyc, input int run_cyc, input bit halt);
        bit halted = 0;
        for (int c = 0; c < ncyc; c++) begin
            exp_t e;
            int h, v;
            bit on, hs_a, vs_a;
            h = c % HP;
            v = (c / HP) % VP;
            on = (c < run_cyc) && !halted;
            hs_a = on && (h < HSW);
            vs_a = on && (v < VSW);
            e.de = on && (h >= HW) && (h < HW + WID) && (v >= VW) && (v < VW + HGT);
            e.x = e.de ? 16'(h - HW) : 16'd0;
            e.y = e.de ? 16'(v - VW) : 16'd0;
            e.pix = e.de ? {e.x[3:0], e.y[3:0]} : 8'd0;
            if (e.de && kill_arm && c < FRAME && int'(e.y) == ky && int'(e.x) >= kx) begin
                e.pix = 8'd0;
                if (halt && int'(e.x) == kx) halted = 1;
            end
            e.hs = hp ? hs_a : !hs_a;
            e.vs = vp ? vs_a : !vs_a;
            q.push_back(e);
        end
    endtask

    // monitor: pops one expectation per clock, late in the cycle
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #6;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(hsync == e.hs, "R1/R4", "hsync", hsync, e.hs);
                chk(vsync == e.vs, "R2/R4", "vsync", vsync, e.vs);
                chk(de == e.de && req_valid == e.de && px == e.x && py == e.y, "R3", "de/x/y",
                    {de, req_valid, px, py}, {e.de, e.de, e.x, e.y});
                chk(pix == e.pix, "R9", "pixel", pix, e.pix);
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(hsync == 1'b1 && vsync == 1'b1, "R4", "idle syncs after reset", {hsync, vsync}, 2'b11);
        chk(de == 1'b0 && irq == 1'b0 && flags == 4'h0, "R8", "reset de/irq/flags", {de, irq, flags}, 0);
        chk(cur_base == 32'h0, "R6", "reset base", cur_base, 0);

        wr(3'd1, {16'(HSW), 16'(HP)});
        wr(3'd2, {16'(VSW), 16'(VP)});
        wr(3'd3, {16'(VW), 16'(HW)});
        wr(3'd4, {16'(HGT), 16'(WID)});
        wr(3'd5, 32'h0000_A000);
        wr(3'd7, 32'h1);

        // R5/R1/R2/R3: one active-low frame, run cleared mid-frame
        wr(3'd0, ctrl(1, 1));
        @(negedge clk);
        push_seq(FRAME + 30, FRAME, 0);
        repeat (40) @(negedge clk);
        chk(cur_base == 32'h0, "R6", "base before frame end", cur_base, 0);
        wr(3'd0, ctrl(0, 1));
        wait (q.size() == 0);
        @(negedge clk);
        chk(cur_base == 32'h0000_A000, "R6", "base after frame end", cur_base, 32'hA000);
        chk(flags == 4'b0011, "R7", "flags after frame", flags, 4'b0011);
        chk(irq == 1'b1, "R8", "irq with done enabled", irq, 1);

        // R7/R8: write-one-to-clear and enable gating
        wr(3'd6, 32'h1);
        chk(flags == 4'b0010, "R7", "clear done only", flags, 4'b0010);
        chk(irq == 1'b0, "R8", "irq with vedge not enabled", irq, 0);
        wr(3'd7, 32'h2);
        chk(irq == 1'b1, "R8", "irq with vedge enabled", irq, 1);
        wr(3'd6, 32'h2);
        chk(flags == 4'b0000 && irq == 1'b0, "R7", "all clear", {flags, irq}, 0);

        // R4/R9: active-high syncs, recovered underflow at (2,1)
        hp = 1'b1; vp = 1'b1;
        wr(3'd5, 32'h0000_B000);
        wr(3'd0, ctrl(0, 1));
        chk(hsync == 1'b0 && vsync == 1'b0, "R4", "idle active-high syncs", {hsync, vsync}, 0);
        kx = 2; ky = 1; kill_arm = 1'b1;
        wr(3'd0, ctrl(1, 1));
        @(negedge clk);
        push_seq(FRAME + 10, FRAME, 0);
        repeat (40) @(negedge clk);
        wr(3'd0, ctrl(0, 1));
        wait (q.size() == 0);
        @(negedge clk);
        kill_arm = 1'b0;
        chk(flags == 4'b0111, "R9", "underflow flag with recover", flags, 4'b0111);
        chk(cur_base == 32'h0000_B000, "R6", "second promotion", cur_base, 32'hB000);

        // R11: stray response while idle
        wr(3'd6, 32'hF);
        @(negedge clk); extra_rsp = 1'b1;
        chk(pix == 8'h0, "R11", "stray response pixel", pix, 0);
        @(negedge clk); extra_rsp = 1'b0;
        chk(flags == 4'b1000, "R11", "overflow flag", flags, 4'b1000);
        chk(irq == 1'b0, "R8", "overflow not enabled", irq, 0);
        wr(3'd7, 32'h8);
        chk(irq == 1'b1, "R8", "overflow enabled", irq, 1);

        // R10: unrecovered underflow at (1,0) halts the raster
        hp = 1'b0; vp = 1'b0;
        wr(3'd0, ctrl(0, 0));
        wr(3'd6, 32'hF);
        kx = 1; ky = 0; kill_arm = 1'b1;
        wr(3'd0, ctrl(1, 0));
        @(negedge clk);
        push_seq(200, 200, 1);
        wait (q.size() == 0);
        @(negedge clk);
        kill_arm = 1'b0;
        chk(flags == 4'b0110, "R10", "flags after halt", flags, 4'b0110);
        // R5: restart from the origin after the halt
        wr(3'd0, ctrl(1, 0));
        @(negedge clk);
        push_seq(30, 30, 0);
        wait (q.size() == 0);
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule